// File: doc/BRIEF.md
# Dual-Bank USB OUT Endpoint Receive Buffer

This block is the device-side receive store for one USB OUT endpoint. On the packet side, a byte stream from the token and data decoder is written into a free bank of 64 bytes. An end-of-packet strobe closes the packet. In the cycle of the packet's first beat, the block returns an ACK or NAK decision. On the CPU side it shows a received flag, a bank-ownership flag, the count of unread bytes and a read-allowed flag. It also gives a single data port for popping bytes and two one-cycle strobes: one clears the received flag and one frees the current bank.

A static configuration input selects one or two banks. With two banks, the host can fill one bank while the CPU drains the other. The CPU's view alternates between the banks each time it frees one. If the next bank is already full when the current one is freed, the received flag sets again at once.

The incoming byte stream has a valid qualifier but no ready: the block never applies back-pressure. Bytes of a packet that was refused, and bytes beyond the bank depth, are dropped. The outgoing data port is a valid/ready stream. A byte moves when `out_valid` and `out_ready` are both high in the same cycle. `out_ready` has no effect while `out_valid` is low, and `out_data` holds steady until the byte is taken.

Top module: `usb_rx_bank_buf`

## Requirements
- R1: After reset, `rx_flag`, `own`, `out_valid` and `irq` are 0 and `byte_cnt` is 0.
- R2: When a packet ends (`in_eop`) and it was accepted into the bank the CPU currently views, `rx_flag` and `own` are 1 from the same clock edge. At that edge `byte_cnt` equals the number of stored bytes.
- R3: `irq` is high exactly while `rx_flag` is 1 and `rx_ie` is 1.
- R4: `rx_flag` clears only at an edge where `rx_clr` is 1; while `rx_clr` is 0 it stays set. If a set event and `rx_clr` fall on the same edge, the flag ends up set.
- R5: `out_valid` is high while `own` is 1 and `byte_cnt` is nonzero. Each transfer lowers `byte_cnt` by one, and `out_data` gives the stored bytes in arrival order.
- R6: An `own_clr` pulse while `own` is 1 frees the viewed bank and clears `own`. With two banks (`cfg_dual`=1) the view moves to the other bank; with one bank it stays on bank 0. An `own_clr` pulse while `own` is 0 has no effect.
- R7: With two banks, a packet can be stored in the other bank while the CPU reads the current one. If that bank is full when the current one is freed, `rx_flag` and `own` are 1 from the same edge and `byte_cnt` shows that bank's count.
- R8: `hs_valid` is 1 in the cycle of a packet's first beat, that is, the first cycle with `in_valid` or `in_eop` outside a packet. `hs_ack` is then 1 (ACK) if the next bank to fill is free and 0 (NAK) if it is not. A refused packet stores no data and leaves the counts unchanged.
- R9: A zero-length packet, meaning `in_eop` with no byte outside a packet, fills a bank with count 0 and sets `rx_flag` and `own`, while `out_valid` stays 0.
- R10: Bytes beyond the 64th of a packet are dropped; the count stops at 64.
- R11: With one bank, a packet arriving while the bank is owned by the CPU is refused. After the bank is freed, the next packet is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_dual | input | 1 | 1 selects two banks, 0 selects one; held static |
| rx_ie | input | 1 | Received-interrupt enable |
| in_valid | input | 1 | Incoming byte present |
| in_data | input | 8 | Incoming byte |
| in_eop | input | 1 | Packet ends; the byte of the same cycle, if any, is its last |
| hs_valid | output | 1 | Handshake decision present (first beat of a packet) |
| hs_ack | output | 1 | 1 = ACK, 0 = NAK |
| rx_flag | output | 1 | Received flag |
| rx_clr | input | 1 | Strobe: clear the received flag |
| own | output | 1 | CPU owns the viewed bank |
| own_clr | input | 1 | Strobe: free the viewed bank |
| byte_cnt | output | 7 | Unread bytes in the viewed bank |
| out_valid | output | 1 | Read allowed; `out_data` holds a byte |
| out_data | output | 8 | Byte at the head of the viewed bank |
| out_ready | input | 1 | CPU takes the byte |
| irq | output | 1 | Endpoint interrupt |

## Verification
Two pairs of actions can fall in the same cycle. In the first, the CPU's `rx_clr` strobe lands on the edge where a bank becomes visible. The bench provokes this in two ways. One is a bank release that reveals an already-full second bank. The other is a packet ending into the viewed, empty bank while the received flag is still set. In both cases the flag is expected to stay set, together with `own` and the new count. In the second pair, the packet side stores into one bank during the very cycles the CPU is popping the other. The bench runs both at once and checks that the viewed count and data are undisturbed.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
  localparam int unsigned NBANK = 2;

  // bank that follows `cur`; a single-bank setup always stays on bank 0
  function automatic logic next_bank(input logic cur, input logic dual);
    return dual ? ~cur : 1'b0;
  endfunction
endpackage

// File: rtl/rxbuf_fill.sv
module rxbuf_fill
  import rxbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_dual,
  input  logic             in_valid,
  input  logic [DW-1:0]    in_data,
  input  logic             in_eop,
  input  logic [NBANK-1:0] bank_full,
  output logic             hs_valid,
  output logic             hs_ack,
  output logic             wr_en,
  output logic             wr_bank,
  output logic [AW-1:0]    wr_addr,
  output logic [DW-1:0]    wr_data,
  output logic             done,
  output logic             done_bank,
  output logic [CW-1:0]    done_cnt
);
  logic          busy, keep, fptr;
  logic [CW-1:0] wcnt, cnt_nxt;
  logic          start, free, active, live, room;

  assign start   = !busy && (in_valid || in_eop);
  assign free    = !bank_full[fptr];
  assign active  = busy || start;
  assign live    = active && (busy ? keep : free);
  assign room    = wcnt < CW'(DEPTH);

  assign hs_valid  = start;
  assign hs_ack    = free;
  assign wr_en     = live && in_valid && room;
  assign wr_bank   = fptr;
  assign wr_addr   = wcnt[AW-1:0];
  assign wr_data   = in_data;
  assign cnt_nxt   = wcnt + CW'(wr_en);
  assign done      = live && in_eop;
  assign done_bank = fptr;
  assign done_cnt  = cnt_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      keep <= 1'b0;
      fptr <= 1'b0;
      wcnt <= '0;
    end else if (active && in_eop) begin
      busy <= 1'b0;
      wcnt <= '0;
      if (live) fptr <= next_bank(fptr, cfg_dual);
    end else if (start) begin
      busy <= 1'b1;
      keep <= free;
      wcnt <= cnt_nxt;
    end else if (busy) begin
      wcnt <= cnt_nxt;
    end
  end
endmodule

// File: rtl/rxbuf_store.sv
module rxbuf_store
  import rxbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic          wr_bank,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_bank,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] bank_q [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [DW-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_bank == 1'(b))) mem[wr_addr] <= wr_data;
    end
    assign bank_q[b] = mem[rd_addr];
  end

  assign rd_data = bank_q[rd_bank];
endmodule

// File: rtl/rxbuf_view.sv
module rxbuf_view
  import rxbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_dual,
  input  logic             done,
  input  logic             done_bank,
  input  logic [CW-1:0]    done_cnt,
  input  logic             rx_clr,
  input  logic             own_clr,
  input  logic             pop,
  output logic [NBANK-1:0] bank_full,
  output logic             view,
  output logic [AW-1:0]    rd_idx,
  output logic             own,
  output logic [CW-1:0]    byte_cnt,
  output logic             rx_flag,
  output logic             out_valid
);
  logic [CW-1:0]    cnt [NBANK];
  logic [NBANK-1:0] full_n;
  logic             view_n, rel, take, rx_set;

  assign own       = bank_full[view];
  assign byte_cnt  = cnt[view];
  assign out_valid = own && (byte_cnt != '0);
  assign take      = out_valid && pop;
  assign rel       = own_clr && own;
  assign view_n    = rel ? next_bank(view, cfg_dual) : view;

  always_comb begin
    full_n = bank_full;
    if (rel)  full_n[view] = 1'b0;
    if (done) full_n[done_bank] = 1'b1;
  end

  // a bank becomes visible: either it fills while the view is empty,
  // or the view moves onto a bank that is already full
  assign rx_set = full_n[view_n] && (!own || rel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_full <= '0;
      view      <= 1'b0;
      rd_idx    <= '0;
      rx_flag   <= 1'b0;
      for (int b = 0; b < NBANK; b++) cnt[b] <= '0;
    end else begin
      bank_full <= full_n;
      view      <= view_n;
      rx_flag   <= rx_set || (rx_flag && !rx_clr);
      if (done) cnt[done_bank] <= done_cnt;
      if (rel) begin
        cnt[view] <= '0;
        rd_idx    <= '0;
      end else if (take) begin
        cnt[view] <= cnt[view] - CW'(1);
        rd_idx    <= rd_idx + AW'(1);
      end
    end
  end
endmodule

// File: rtl/usb_rx_bank_buf.sv
module usb_rx_bank_buf
  import rxbuf_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_dual,
  input  logic          rx_ie,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          in_eop,
  output logic          hs_valid,
  output logic          hs_ack,
  output logic          rx_flag,
  input  logic          rx_clr,
  output logic          own,
  input  logic          own_clr,
  output logic [CW-1:0] byte_cnt,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready,
  output logic          irq
);
  logic [NBANK-1:0] bank_full;
  logic             wr_en, wr_bank, done, done_bank, view;
  logic [AW-1:0]    wr_addr, rd_idx;
  logic [DW-1:0]    wr_data;
  logic [CW-1:0]    done_cnt;

  rxbuf_fill #(.DEPTH(DEPTH), .DW(DW)) u_fill (
    .clk(clk), .rst_n(rst_n), .cfg_dual(cfg_dual),
    .in_valid(in_valid), .in_data(in_data), .in_eop(in_eop),
    .bank_full(bank_full), .hs_valid(hs_valid), .hs_ack(hs_ack),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done), .done_bank(done_bank), .done_cnt(done_cnt)
  );

  rxbuf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_bank(view), .rd_addr(rd_idx), .rd_data(out_data)
  );

  rxbuf_view #(.DEPTH(DEPTH)) u_view (
    .clk(clk), .rst_n(rst_n), .cfg_dual(cfg_dual),
    .done(done), .done_bank(done_bank), .done_cnt(done_cnt),
    .rx_clr(rx_clr), .own_clr(own_clr), .pop(out_ready),
    .bank_full(bank_full), .view(view), .rd_idx(rd_idx), .own(own),
    .byte_cnt(byte_cnt), .rx_flag(rx_flag), .out_valid(out_valid)
  );

  assign irq = rx_flag && rx_ie;
endmodule

// File: rtl/rxbuf_chk.sv
module rxbuf_chk #(
  parameter int unsigned DEPTH = 64,
  localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_dual,
  input logic          hs_valid,
  input logic          hs_ack,
  input logic          rx_flag,
  input logic          rx_clr,
  input logic          own,
  input logic          own_clr,
  input logic [CW-1:0] byte_cnt,
  input logic          out_valid,
  input logic          out_ready
);
  // R4
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_flag && !rx_clr) |=> rx_flag);

  // R2
  flag_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_flag) |-> own);

  // R5
  valid_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (own && byte_cnt != '0));

  // R5
  pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !own_clr) |=> (byte_cnt == $past(byte_cnt) - CW'(1)));

  // R8
  nak_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_valid && !hs_ack && !own_clr && !(out_valid && out_ready)) |=> $stable(byte_cnt));

  // R10
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_cnt <= CW'(DEPTH));

  // R6
  single_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_dual && own && own_clr) |=> !own);
endmodule

bind usb_rx_bank_buf rxbuf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_dual(cfg_dual),
  .hs_valid(hs_valid), .hs_ack(hs_ack), .rx_flag(rx_flag), .rx_clr(rx_clr),
  .own(own), .own_clr(own_clr), .byte_cnt(byte_cnt),
  .out_valid(out_valid), .out_ready(out_ready)
);

// File: tb/sim_usb_rx_bank_buf.sv
module sim_usb_rx_bank_buf;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 4;
  localparam int VEC_LEN  [NV] = '{1, 5, 64, 70};
  localparam int VEC_SEED [NV] = '{8'h10, 8'hA0, 8'h00, 8'h37};
  localparam int VEC_CNT  [NV] = '{1, 5, 64, 64};

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_dual = 1'b0, rx_ie = 1'b0;
  logic in_valid = 1'b0, in_eop = 1'b0, rx_clr = 1'b0, own_clr = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = '0;
  logic hs_valid, hs_ack, rx_flag, own, out_valid, irq;
  logic [6:0] byte_cnt;
  logic [7:0] out_data;

  int n_chk = 0, n_fail = 0;
  bit hv, ha, hv2, ha2;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_rx_bank_buf u0 (
    .clk(clk), .rst_n(rst_n), .cfg_dual(cfg_dual), .rx_ie(rx_ie),
    .in_valid(in_valid), .in_data(in_data), .in_eop(in_eop),
    .hs_valid(hs_valid), .hs_ack(hs_ack), .rx_flag(rx_flag), .rx_clr(rx_clr),
    .own(own), .own_clr(own_clr), .byte_cnt(byte_cnt), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit dual);
    rst_n = 1'b0; cfg_dual = dual;
    in_valid = 0; in_eop = 0; rx_clr = 0; own_clr = 0; out_ready = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // drives one packet from a negedge; returns the handshake seen on its first beat
  task automatic send(input int len, input int seed, output bit v, output bit a);
    if (len == 0) begin
      @(negedge clk); in_eop = 1'b1;
      #1 v = hs_valid; a = hs_ack;
    end else begin
      for (int i = 0; i < len; i++) begin
        @(negedge clk);
        in_valid = 1'b1; in_data = 8'((seed + i) & 255); in_eop = (i == len - 1);
        if (i == 0) begin #1 v = hs_valid; a = hs_ack; end
      end
    end
    @(negedge clk); in_valid = 1'b0; in_eop = 1'b0;
  endtask

  task automatic drain(input int n, input int seed, input string req);
    for (int i = 0; i < n; i++) begin
      chk({req, " out_valid"}, int'(out_valid), 1);
      chk({req, " out_data"}, int'(out_data), (seed + i) & 255);
      chk({req, " byte_cnt"}, int'(byte_cnt), n - i);
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
    end
    chk({req, " empty cnt"}, int'(byte_cnt), 0);
    chk({req, " empty valid"}, int'(out_valid), 0);
  endtask

  task automatic pulse_rx_clr;
    rx_clr = 1'b1; @(negedge clk); rx_clr = 1'b0;
  endtask

  task automatic pulse_release;
    own_clr = 1'b1; @(negedge clk); own_clr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R1 reset state
    rx_ie = 1'b1;
    do_reset(1'b0);
    chk("R1 rx_flag", int'(rx_flag), 0);
    chk("R1 own", int'(own), 0);
    chk("R1 byte_cnt", int'(byte_cnt), 0);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 irq", int'(irq), 0);

    // vector table, two-bank mode
    do_reset(1'b1);
    for (int v = 0; v < NV; v++) begin
      send(VEC_LEN[v], VEC_SEED[v], hv, ha);
      chk("R8 hs_valid", int'(hv), 1);
      chk("R8 hs_ack", int'(ha), 1);
      chk("R2 rx_flag", int'(rx_flag), 1);
      chk("R2 own", int'(own), 1);
      chk("R2 R10 byte_cnt", int'(byte_cnt), VEC_CNT[v]);
      chk("R3 irq set", int'(irq), 1);
      pulse_rx_clr();
      chk("R4 cleared", int'(rx_flag), 0);
      chk("R3 irq clear", int'(irq), 0);
      drain(VEC_CNT[v], VEC_SEED[v], "R5");
      pulse_release();
      chk("R6 freed", int'(own), 0);
    end

    // R4 / R3 / R11 single-bank
    rx_ie = 1'b0;
    do_reset(1'b0);
    send(2, 8'h55, hv, ha);
    repeat (3) @(negedge clk);
    chk("R4 holds without clear", int'(rx_flag), 1);
    chk("R3 masked", int'(irq), 0);
    rx_ie = 1'b1; #1;
    chk("R3 enabled", int'(irq), 1);
    send(3, 8'hC0, hv, ha);
    chk("R11 nak valid", int'(hv), 1);
    chk("R11 R8 nak", int'(ha), 0);
    chk("R8 nak count", int'(byte_cnt), 2);
    chk("R8 nak data", int'(out_data), 8'h55);
    pulse_release();
    chk("R6 single freed", int'(own), 0);
    send(3, 8'h70, hv, ha);
    chk("R11 accept after free", int'(ha), 1);
    chk("R6 single view bank0", int'(own), 1);
    drain(3, 8'h70, "R11");

    // R6 release while not owned is ignored
    do_reset(1'b1);
    pulse_release();
    send(4, 8'h20, hv, ha);
    chk("R6 ignored release own", int'(own), 1);
    chk("R6 ignored release cnt", int'(byte_cnt), 4);

    // R7 fill other bank while draining current
    fork
      send(2, 8'h90, hv2, ha2);
      begin pulse_rx_clr(); drain(4, 8'h20, "R7 concurrent"); end
    join
    chk("R7 second ack", int'(ha2), 1);
    chk("R7 flag stays clear", int'(rx_flag), 0);
    send(3, 8'hE0, hv, ha);
    chk("R8 both full nak", int'(ha), 0);
    pulse_release();
    chk("R7 immediate flag", int'(rx_flag), 1);
    chk("R7 immediate own", int'(own), 1);
    chk("R7 next count", int'(byte_cnt), 2);

    // R4 collision: release revealing full bank with rx_clr on the same edge
    send(3, 8'h40, hv, ha);
    chk("R8 refill ack", int'(ha), 1);
    drain(2, 8'h90, "R7 bank1 data");
    own_clr = 1'b1; rx_clr = 1'b1;
    @(negedge clk);
    own_clr = 1'b0; rx_clr = 1'b0;
    chk("R4 set wins on release", int'(rx_flag), 1);
    chk("R7 own after release", int'(own), 1);
    chk("R7 count after release", int'(byte_cnt), 3);

    // R4 collision: packet end into viewed empty bank with rx_clr
    drain(3, 8'h40, "R5 bank0 data");
    pulse_release();
    chk("R6 view empty", int'(own), 0);
    chk("R4 flag kept", int'(rx_flag), 1);
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'h3C; in_eop = 1'b1; rx_clr = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_eop = 1'b0; rx_clr = 1'b0;
    chk("R4 set wins on fill", int'(rx_flag), 1);
    chk("R2 own on fill", int'(own), 1);
    chk("R2 count on fill", int'(byte_cnt), 1);
    chk("R5 data on fill", int'(out_data), 8'h3C);

    // R9 zero-length packet
    do_reset(1'b1);
    send(0, 0, hv, ha);
    chk("R9 hs_valid", int'(hv), 1);
    chk("R9 ack", int'(ha), 1);
    chk("R9 rx_flag", int'(rx_flag), 1);
    chk("R9 own", int'(own), 1);
    chk("R9 count", int'(byte_cnt), 0);
    chk("R9 no data", int'(out_valid), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule